// File: doc/BRIEF.md
# Pulsed-Carrier Wake-Up Sequence Generator

This block drives the reader carrier through a fixed wake-up handshake for a low-frequency tag that answers at a very slow data rate. After a start request it switches the carrier through seven timed phases. The three bursts have very unequal lengths, and each burst is followed by an equal gap. A final carrier-on period closes the sequence. The block then raises a one-cycle strobe that names the capture mode to launch. It keeps the carrier on and stays busy until the capture logic reports that it has finished. It then drops the carrier and returns to idle.

Every duration is counted in ticks of a 1 µs timebase that arrives on `tick_us_i`, and each duration is a parameter. The defaults are the trimmed handshake values, in the order the phases run:

| Phase | Carrier | Default length |
|---|---|---|
| 0 | on | 740 |
| 1 | off | 2035 |
| 2 | on | 3330 |
| 3 | off | 2035 |
| 4 | on | 740 |
| 5 | off | 2035 |
| 6 | on | 1000 |

These defaults add up to 11915 µs before the hand-off. The capture logic is told which mode to run through a 2-bit code:

- 0: raw capture of a fixed sample count.
- 1: capture with Manchester interpretation.
- 2: capture using the stored sampling settings.

The state machine has four states:

- IDLE: carrier off, not busy.
- RUN: stepping through the seven phases.
- DISPATCH: a single cycle that issues the capture strobe.
- CAPTURE: carrier held on while capture runs.

It has four transitions:

- *accept*: IDLE→RUN, when `start_i` is high in IDLE.
- *sequence end*: RUN→DISPATCH, on the tick that completes phase 6.
- *hand-off*: DISPATCH→CAPTURE, always after one cycle.
- *finish*: CAPTURE→IDLE, when `cap_done_i` is high.

Top module: `wake_seq_gen`

## Requirements
- R1: After reset `carrier_en_o`, `cap_strobe_o` and `busy_o` are all low, and while `busy_o` is low the carrier and the strobe stay low.
- R2: A `start_i` pulse seen in IDLE makes `busy_o` and `carrier_en_o` high in the next cycle, and phase 0 starts.
- R3: The carrier-on phases 0, 2 and 4 last 740, 3330 and 740 ticks, in that order.
- R4: The carrier-off phases 1, 3 and 5 each last 2035 ticks, and the carrier is on and off strictly alternately across phases 0 to 6.
- R5: Phase 6 keeps the carrier on for 1000 ticks. The cycle after its last tick, `cap_strobe_o` is high for exactly one cycle, and the carrier stays on from then until capture ends.
- R6: `cap_mode_o` carries the mode code sampled from `mode_i` at the accepted start: 0 is raw capture, 1 is Manchester capture, 2 is configured capture, and code 3 is reported as 0. Later changes of `mode_i` have no effect on it.
- R7: `start_i` is ignored while busy. The phase lengths, the reported mode and the capture hold stay as they are.
- R8: `cap_done_i` high during CAPTURE makes `busy_o` and `carrier_en_o` low in the next cycle. `cap_done_i` outside CAPTURE has no effect.
- R9: Phase timing advances only on cycles where `tick_us_i` is high. Cycles without a tick leave the phase timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a wake-up sequence |
| mode_i | input | 2 | Capture mode to launch (3 treated as 0) |
| tick_us_i | input | 1 | One-cycle pulse per microsecond |
| cap_done_i | input | 1 | Capture logic has finished |
| carrier_en_o | output | 1 | Reader carrier enable |
| cap_strobe_o | output | 1 | One-cycle capture launch strobe |
| cap_mode_o | output | 2 | Capture mode latched at start |
| busy_o | output | 1 | Sequence or capture in progress |

## Verification
The assertions assume the following about the inputs:

- `tick_us_i` is a single-cycle pulse, so every high cycle counts as one microsecond.
- `cap_done_i` is meaningful only once the strobe has been issued.
- All phase durations are non-zero, so the timer always stays below its limit.

The stimulus draws tick spacing from a seeded `$urandom`, with densities from every cycle to one in three. It asserts `cap_done_i` only as a one-cycle pulse, either in mid-sequence to show it is ignored or after the strobe to end capture. It re-pulses `start_i` at random points inside the run and while capture is held. The expected phase lengths are counted in ticks, not in cycles, so they do not depend on the tick spacing.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_DISPATCH = 2'd2,
        ST_CAPTURE  = 2'd3
    } wake_state_t;

    localparam int unsigned PHASE_COUNT = 7;
    localparam int unsigned PHASE_W     = $clog2(PHASE_COUNT);
    localparam int unsigned MODE_W      = 2;

    // Folds the unused code onto the raw capture mode
    function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m);
        return (m == 2'd3) ? 2'd0 : m;
    endfunction

endpackage

// File: rtl/wake_phase_table.sv
module wake_phase_table
    import wake_pkg::*;
#(
    parameter int unsigned SHORT_BURST_US = 740,
    parameter int unsigned LONG_BURST_US  = 3330,
    parameter int unsigned GAP_US         = 2035,
    parameter int unsigned TAIL_US        = 1000,
    parameter int unsigned DUR_W          = 12
) (
    input  logic [PHASE_W-1:0] phase_i,
    output logic [DUR_W-1:0]   dur_o,
    output logic               burst_o
);

    // Even phases drive the carrier, odd phases are gaps
    assign burst_o = ~phase_i[0];

    always_comb begin
        unique case (phase_i)
            3'd0, 3'd4:       dur_o = DUR_W'(SHORT_BURST_US);
            3'd2:             dur_o = DUR_W'(LONG_BURST_US);
            3'd1, 3'd3, 3'd5: dur_o = DUR_W'(GAP_US);
            default:          dur_o = DUR_W'(TAIL_US);
        endcase
    end

    initial begin
        // R3
        short_nonzero_chk: assert (SHORT_BURST_US > 0 && LONG_BURST_US > 0);
        // R4
        gap_nonzero_chk: assert (GAP_US > 0 && TAIL_US > 0);
    end

endmodule

// File: rtl/wake_tick_timer.sv
module wake_tick_timer #(
    parameter int unsigned DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [DUR_W-1:0] limit_i,
    output logic             done_o
);

    logic [DUR_W-1:0] cnt_q;

    assign done_o = tick_i && (cnt_q == limit_i - DUR_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || done_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + DUR_W'(1);
        end
    end

    // R9
    cnt_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit_i);

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
    import wake_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               cap_done_i,
    input  logic               phase_done_i,
    input  logic               burst_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               timer_clear_o,
    output logic               carrier_en_o,
    output logic               cap_strobe_o,
    output logic [MODE_W-1:0]  cap_mode_o,
    output logic               busy_o
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PHASE_COUNT - 1);

    wake_state_t        state_q, state_d;
    logic [PHASE_W-1:0] phase_q;
    logic [MODE_W-1:0]  mode_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_RUN;
            ST_RUN:      if (phase_done_i && phase_q == LAST_PHASE) state_d = ST_DISPATCH;
            ST_DISPATCH: state_d = ST_CAPTURE;
            ST_CAPTURE:  if (cap_done_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Phase index and latched mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mode_q  <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                phase_q <= '0;
                if (start_i) mode_q <= legal_mode(mode_i);
            end else if (state_q == ST_RUN && phase_done_i && phase_q != LAST_PHASE) begin
                phase_q <= phase_q + PHASE_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        carrier_en_o  = 1'b0;
        cap_strobe_o  = 1'b0;
        busy_o        = 1'b1;
        timer_clear_o = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_RUN: begin
                carrier_en_o  = burst_i;
                timer_clear_o = 1'b0;
            end
            ST_DISPATCH: begin
                carrier_en_o = 1'b1;
                cap_strobe_o = 1'b1;
            end
            ST_CAPTURE: begin
                carrier_en_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign phase_o    = phase_q;
    assign cap_mode_o = mode_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!carrier_en_o && !cap_strobe_o));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && carrier_en_o));

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe_o |=> (!cap_strobe_o && carrier_en_o));

    // R6
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe_o |-> (cap_mode_o != 2'd3));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(cap_mode_o));

    // R8
    drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(cap_done_i) && !carrier_en_o));

    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_PHASE);

endmodule

// File: rtl/wake_seq_gen.sv
module wake_seq_gen
    import wake_pkg::*;
#(
    parameter int unsigned SHORT_BURST_US = 740,
    parameter int unsigned LONG_BURST_US  = 3330,
    parameter int unsigned GAP_US         = 2035,
    parameter int unsigned TAIL_US        = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic       tick_us_i,
    input  logic       cap_done_i,
    output logic       carrier_en_o,
    output logic       cap_strobe_o,
    output logic [1:0] cap_mode_o,
    output logic       busy_o
);

    localparam int unsigned MAX_A  = (SHORT_BURST_US > LONG_BURST_US) ? SHORT_BURST_US : LONG_BURST_US;
    localparam int unsigned MAX_B  = (GAP_US > TAIL_US) ? GAP_US : TAIL_US;
    localparam int unsigned MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned DUR_W  = $clog2(MAX_US + 1);

    logic [PHASE_W-1:0] phase;
    logic [DUR_W-1:0]   phase_len;
    logic               phase_burst;
    logic               phase_done;
    logic               timer_clear;

    wake_phase_table #(
        .SHORT_BURST_US (SHORT_BURST_US),
        .LONG_BURST_US  (LONG_BURST_US),
        .GAP_US         (GAP_US),
        .TAIL_US        (TAIL_US),
        .DUR_W          (DUR_W)
    ) i_table (
        .phase_i (phase),
        .dur_o   (phase_len),
        .burst_o (phase_burst)
    );

    wake_tick_timer #(
        .DUR_W (DUR_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (timer_clear),
        .tick_i  (tick_us_i),
        .limit_i (phase_len),
        .done_o  (phase_done)
    );

    wake_seq_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .mode_i        (mode_i),
        .cap_done_i    (cap_done_i),
        .phase_done_i  (phase_done),
        .burst_i       (phase_burst),
        .phase_o       (phase),
        .timer_clear_o (timer_clear),
        .carrier_en_o  (carrier_en_o),
        .cap_strobe_o  (cap_strobe_o),
        .cap_mode_o    (cap_mode_o),
        .busy_o        (busy_o)
    );

endmodule

// File: tb/test_wake_seq_gen.sv
module test_wake_seq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       tick_us_i = 1'b0;
    logic       cap_done_i = 1'b0;
    logic       carrier_en_o;
    logic       cap_strobe_o;
    logic [1:0] cap_mode_o;
    logic       busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wake_seq_gen i_wake_seq_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .tick_us_i    (tick_us_i),
        .cap_done_i   (cap_done_i),
        .carrier_en_o (carrier_en_o),
        .cap_strobe_o (cap_strobe_o),
        .cap_mode_o   (cap_mode_o),
        .busy_o       (busy_o)
    );

    function automatic int exp_len(input int seg);
        case (seg)
            0, 4:    return 740;
            2:       return 3330;
            1, 3, 5: return 2035;
            default: return 1000;
        endcase
    endfunction

    function automatic logic [1:0] exp_mode(input logic [1:0] m);
        return (m == 2'd3) ? 2'd0 : m;
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic logic draw_tick(input int spread);
        return ($urandom % spread) == 0;
    endfunction

    task automatic do_run(input logic [1:0] mode, input int spread,
                          input int poke_at, input int early_done_at);
        int seg = 0;
        int cnt = 0;
        int iter = 0;
        logic prev_car;
        logic prev_tick;
        logic car;
        bit got_strobe = 1'b0;
        @(negedge clk);
        tick_us_i = 1'b0;
        start_i = 1'b1;
        mode_i = mode;
        @(negedge clk);
        start_i = 1'b0;
        mode_i = 2'($urandom);
        // R2: busy and carrier on the cycle after the accepted start
        check("R2 busy", busy_o, 1);
        check("R2 carrier", carrier_en_o, 1);
        prev_car = carrier_en_o;
        prev_tick = draw_tick(spread);
        tick_us_i = prev_tick;
        while (iter < 100000) begin
            @(negedge clk);
            start_i = 1'b0;
            cap_done_i = 1'b0;
            iter++;
            if (prev_tick) cnt++;
            car = carrier_en_o;
            if (cap_strobe_o) begin
                // R5: final on period in ticks
                check("R5 tail ticks", cnt, exp_len(6));
                check("R4 phase count", seg, 6);
                got_strobe = 1'b1;
                break;
            end
            if (car != prev_car) begin
                // R3 bursts (even), R4 gaps (odd); R9 ticks only
                if (seg % 2 == 0) check("R3 burst ticks", cnt, exp_len(seg));
                else              check("R4 gap ticks", cnt, exp_len(seg));
                check("R4 alternation", prev_car, (seg % 2 == 0) ? 1 : 0);
                seg++;
                cnt = 0;
            end
            prev_car = car;
            if (iter == poke_at) start_i = 1'b1;        // R7
            if (iter == early_done_at) cap_done_i = 1'b1; // R8 ignored
            prev_tick = draw_tick(spread);
            tick_us_i = prev_tick;
        end
        if (!got_strobe) begin
            check("R5 strobe seen", 0, 1);
            return;
        end
        // R6: reported mode
        check("R6 mode", cap_mode_o, exp_mode(mode));
        check("R5 carrier at strobe", carrier_en_o, 1);
        @(negedge clk);
        check("R5 strobe one cycle", cap_strobe_o, 0);
        check("R5 carrier held", carrier_en_o, 1);
        // R7: start during capture ignored
        start_i = 1'b1;
        mode_i = 2'd1 + 2'(mode);
        @(negedge clk);
        start_i = 1'b0;
        repeat (2 + ($urandom % 20)) @(negedge clk);
        check("R7 busy held", busy_o, 1);
        check("R7 no new strobe", cap_strobe_o, 0);
        check("R7 mode kept", cap_mode_o, exp_mode(mode));
        cap_done_i = 1'b1;
        @(negedge clk);
        cap_done_i = 1'b0;
        tick_us_i = 1'b0;
        check("R8 busy low", busy_o, 0);
        check("R8 carrier low", carrier_en_o, 0);
        repeat (3) @(negedge clk);
        check("R1 idle carrier", carrier_en_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 carrier", carrier_en_o, 0);
        check("R1 strobe", cap_strobe_o, 0);
        check("R1 busy", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: done while idle has no effect
        cap_done_i = 1'b1;
        @(negedge clk);
        cap_done_i = 1'b0;
        check("R8 idle done", busy_o, 0);
        do_run(2'd0, 1, 500, 2000);
        do_run(2'd1, 2, 9000, 300);
        do_run(2'd2, 1, 11000, 7000);
        do_run(2'd3, 3, 20, 30000);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule